// File: doc/BRIEF.md
# Self-Timed Flash Programming Controller

This block models the programming side of a small on-chip code flash. An external programmer drives a parallel address bus, a byte of data, an operation select and an active-low strobe. A byte write starts when the strobe returns high. It then runs on an internal cycle counter, and the ready output stays low until the write completes. While the write runs, reading the target byte returns its complement, so the programmer can poll for completion on the data bus.

A chip erase needs the erase operation selected with the strobe held low for a set number of clock cycles. It sets every byte to ones and clears all lock bits. Three lock bits can be set through the same self-timed path. Setting either of the first two lock bits hides array contents from verify reads. Setting the first one also freezes the external-access level that was captured just after reset. Identification bytes come back from a separate signature operation.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset, ready_o is 1, reject_o is 0, and a verify read (mode_i = 0) of any address returns FFh.
- R2: A strobe rising edge with mode_i = 1 while idle starts a byte write. ready_o is 0 for exactly WRITE_CYC cycles after that edge, and then the byte is stored.
- R3: While a byte write is pending, a verify read at its address returns the bitwise inverse of the data being written. Verify reads at other addresses return the stored contents.
- R4: A byte write can only clear bits: the stored value becomes old AND new.
- R5: A program or lock request (strobe rising edge with mode_i = 1 or 2) during a pending write is ignored. reject_o is 1 for the one cycle after that edge, and the requested address is left unchanged.
- R6: Holding mode_i = 3 with strobe_i low for ERASE_CYC consecutive clock edges, while no write is pending, sets all bytes to FFh and clears all lock bits. ready_o is low from the first edge of the hold until the erase completes. A strobe falling edge in mode 3 during a pending write raises reject_o.
- R7: Releasing the strobe before ERASE_CYC edges have passed leaves the array and the lock bits unchanged.
- R8: A strobe rising edge with mode_i = 2 sets lock bit addr_i[1:0] (0..2) after WRITE_CYC cycles. While lock bit 0 or lock bit 1 is set, verify reads return FFh. Lock bit 2 alone does not block verify.
- R9: A signature read (mode_i = 4) returns 1Eh at address 30h, 51h at 31h, and 05h (HV_VARIANT = 0) or FFh (HV_VARIANT = 1) at 32h. It returns FFh at every other address. Mode values 5 to 7 return FFh.
- R10: ea_o follows ext_acc_i while lock bit 0 is clear. Once lock bit 0 is set, ea_o holds the ext_acc_i level sampled on the first clock edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Byte address |
| data_i | input | 8 | Write data |
| mode_i | input | 3 | Operation: 0 verify, 1 program, 2 lock, 3 erase, 4 signature |
| strobe_i | input | 1 | Program/erase strobe, idle high |
| ext_acc_i | input | 1 | External-access level |
| data_o | output | 8 | Read data |
| ready_o | output | 1 | 1 = ready, 0 = busy |
| reject_o | output | 1 | One-cycle pulse for an ignored request |
| ea_o | output | 1 | Effective external-access level |

## Verification
The bench builds the block with AW = 8, WRITE_CYC = 5, ERASE_CYC = 20 and HV_VARIANT = 0. With these values a whole write window, a complete erase and an aborted erase each take only a few dozen cycles. They also let every array byte be tracked in the reference model, and they bring the 5 V signature byte into reach. The short write window lets the bench land requests on the last busy cycle and land erase holds inside a pending write.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  typedef enum logic [2:0] {
    OP_VERIFY = 3'd0,
    OP_PROG   = 3'd1,
    OP_LOCK   = 3'd2,
    OP_ERASE  = 3'd3,
    OP_SIG    = 3'd4
  } op_e;

  localparam logic [7:0] BLANK    = 8'hFF;
  localparam logic [7:0] SIG_MFR  = 8'h1E;
  localparam logic [7:0] SIG_DEV  = 8'h51;
  localparam logic [7:0] SIG_HV   = 8'hFF;
  localparam logic [7:0] SIG_LV   = 8'h05;
  localparam int         SIG_BASE = 'h30;
  localparam int         NLOCK    = 3;
endpackage

// File: rtl/fpc_array.sv
module fpc_array #(
  parameter int AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          erase_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (erase_i) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (we_i) begin
      // programming only clears bits
      mem_q[waddr_i] <= mem_q[waddr_i] & wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/fpc_write_seq.sv
module fpc_write_seq #(
  parameter int AW        = 10,
  parameter int WRITE_CYC = 200
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          lock_op_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  output logic          busy_o,
  output logic          poll_o,
  output logic          byte_commit_o,
  output logic          lock_commit_o,
  output logic          reject_o,
  output logic [AW-1:0] tgt_addr_o,
  output logic [7:0]    tgt_data_o
);
  localparam int CW = $clog2(WRITE_CYC + 1);

  logic          busy_q, lock_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic          done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      lock_q <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(WRITE_CYC - 1);
      lock_q <= lock_op_i;
      addr_q <= addr_i;
      data_q <= data_i;
    end
  end

  assign done          = busy_q && (cnt_q == '0);
  assign busy_o        = busy_q;
  assign poll_o        = busy_q && !lock_q;
  assign byte_commit_o = done && !lock_q;
  assign lock_commit_o = done && lock_q;
  assign reject_o      = start_i && busy_q;
  assign tgt_addr_o    = addr_q;
  assign tgt_data_o    = data_q;
endmodule

// File: rtl/fpc_erase_det.sv
module fpc_erase_det #(
  parameter int ERASE_CYC = 1_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic block_i,
  output logic active_o,
  output logic erase_o
);
  localparam int CW = $clog2(ERASE_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic          last;

  assign last    = (cnt_q == CW'(ERASE_CYC - 1));
  assign erase_o = hold_i && !block_i && !done_q && last;
  assign active_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!hold_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (block_i) begin
      cnt_q <= '0;
    end else if (!done_q) begin
      if (last) begin
        cnt_q  <= '0;
        done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fpc_lock.sv
module fpc_lock
  import fpc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [1:0]       idx_i,
  input  logic             clear_i,
  input  logic             ext_acc_i,
  output logic [NLOCK-1:0] lock_o,
  output logic             ea_o
);
  logic [NLOCK-1:0] lock_q;
  logic             init_q, ea_q;

  for (genvar g = 0; g < NLOCK; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                lock_q[g] <= 1'b0;
      else if (clear_i)                           lock_q[g] <= 1'b0;
      else if (set_i && (int'(idx_i) == g))       lock_q[g] <= 1'b1;
    end
  end

  // capture the access level on the first edge after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= 1'b1;
      ea_q   <= 1'b0;
    end else if (init_q) begin
      init_q <= 1'b0;
      ea_q   <= ext_acc_i;
    end
  end

  assign lock_o = lock_q;
  assign ea_o   = lock_q[0] ? ea_q : ext_acc_i;
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import fpc_pkg::*;
#(
  parameter int AW         = 10,
  parameter int WRITE_CYC  = 200,
  parameter int ERASE_CYC  = 1_000_000,
  parameter bit HV_VARIANT = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  input  logic [2:0]    mode_i,
  input  logic          strobe_i,
  input  logic          ext_acc_i,
  output logic [7:0]    data_o,
  output logic          ready_o,
  output logic          reject_o,
  output logic          ea_o
);
  localparam logic [7:0] SIG_VAR = HV_VARIANT ? SIG_HV : SIG_LV;

  logic             strobe_q, reject_q;
  logic             rise, fall, prog_req, hold, erase_rej;
  logic             wr_busy, poll, byte_commit, lock_commit, wr_rej;
  logic             er_active, erase_pulse;
  logic [AW-1:0]    tgt_addr;
  logic [7:0]       tgt_data, arr_rdata, rd;
  logic [NLOCK-1:0] lock_q;
  op_e              op;

  assign op        = op_e'(mode_i);
  assign rise      = strobe_i && !strobe_q;
  assign fall      = !strobe_i && strobe_q;
  assign prog_req  = rise && (op == OP_PROG || op == OP_LOCK);
  assign hold      = (op == OP_ERASE) && !strobe_i;
  assign erase_rej = hold && fall && wr_busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q <= 1'b1;
      reject_q <= 1'b0;
    end else begin
      strobe_q <= strobe_i;
      reject_q <= wr_rej || erase_rej;
    end
  end

  fpc_write_seq #(.AW(AW), .WRITE_CYC(WRITE_CYC)) u_wr (
    .clk_i, .rst_ni,
    .start_i      (prog_req),
    .lock_op_i    (op == OP_LOCK),
    .addr_i       (addr_i),
    .data_i       (data_i),
    .busy_o       (wr_busy),
    .poll_o       (poll),
    .byte_commit_o(byte_commit),
    .lock_commit_o(lock_commit),
    .reject_o     (wr_rej),
    .tgt_addr_o   (tgt_addr),
    .tgt_data_o   (tgt_data)
  );

  fpc_erase_det #(.ERASE_CYC(ERASE_CYC)) u_er (
    .clk_i, .rst_ni,
    .hold_i  (hold),
    .block_i (wr_busy),
    .active_o(er_active),
    .erase_o (erase_pulse)
  );

  fpc_array #(.AW(AW)) u_arr (
    .clk_i, .rst_ni,
    .erase_i(erase_pulse),
    .we_i   (byte_commit),
    .waddr_i(tgt_addr),
    .wdata_i(tgt_data),
    .raddr_i(addr_i),
    .rdata_o(arr_rdata)
  );

  fpc_lock u_lock (
    .clk_i, .rst_ni,
    .set_i    (lock_commit),
    .idx_i    (tgt_addr[1:0]),
    .clear_i  (erase_pulse),
    .ext_acc_i(ext_acc_i),
    .lock_o   (lock_q),
    .ea_o     (ea_o)
  );

  always_comb begin
    rd = BLANK;
    case (op)
      OP_VERIFY: begin
        if (!(lock_q[0] || lock_q[1])) begin
          rd = (poll && addr_i == tgt_addr) ? ~tgt_data : arr_rdata;
        end
      end
      OP_SIG: begin
        if      (addr_i == AW'(SIG_BASE))     rd = SIG_MFR;
        else if (addr_i == AW'(SIG_BASE + 1)) rd = SIG_DEV;
        else if (addr_i == AW'(SIG_BASE + 2)) rd = SIG_VAR;
      end
      default: rd = BLANK;
    endcase
  end

  assign data_o   = rd;
  assign ready_o  = !(wr_busy || er_active);
  assign reject_o = reject_q;
endmodule

// File: rtl/fpc_checker.sv
module fpc_checker
  import fpc_pkg::*;
#(
  parameter int AW = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [AW-1:0]    addr_i,
  input logic [2:0]       mode_i,
  input logic             strobe_i,
  input logic [7:0]       data_o,
  input logic             ready_o,
  input logic             reject_o,
  input logic             strobe_q,
  input logic             poll,
  input logic [AW-1:0]    tgt_addr,
  input logic [7:0]       tgt_data,
  input logic [NLOCK-1:0] lock_q,
  input logic             erase_pulse
);
  p_start_drops_ready_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OP_PROG && strobe_i && !strobe_q && ready_o) |=> !ready_o);

  p_poll_inverse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OP_VERIFY && poll && addr_i == tgt_addr && lock_q[1:0] == 2'b00)
      |-> data_o == ~tgt_data);

  p_reject_only_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_o |-> $past(!ready_o));

  p_erase_clears_locks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_pulse |=> lock_q == '0);

  p_locked_blank_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OP_VERIFY && (lock_q[0] || lock_q[1])) |-> data_o == BLANK);

  p_sig_mfr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OP_SIG && addr_i == AW'(SIG_BASE)) |-> data_o == SIG_MFR);
endmodule

bind flash_prog_ctrl fpc_checker #(.AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .mode_i     (mode_i),
  .strobe_i   (strobe_i),
  .data_o     (data_o),
  .ready_o    (ready_o),
  .reject_o   (reject_o),
  .strobe_q   (strobe_q),
  .poll       (poll),
  .tgt_addr   (tgt_addr),
  .tgt_data   (tgt_data),
  .lock_q     (lock_q),
  .erase_pulse(erase_pulse)
);

// File: tb/flash_prog_ctrl_tb_top.sv
module flash_prog_ctrl_tb_top;
  localparam int AW = 8;
  localparam int W  = 5;
  localparam int E  = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = '0;
  logic [2:0]    op = '0;
  logic          strobe = 1'b1;
  logic          ext = 1'b1;
  logic [7:0]    dout;
  logic          ready, reject, ea;

  int applied = 0;
  int fails = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  flash_prog_ctrl #(.AW(AW), .WRITE_CYC(W), .ERASE_CYC(E), .HV_VARIANT(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .data_i(din), .mode_i(op),
    .strobe_i(strobe), .ext_acc_i(ext), .data_o(dout), .ready_o(ready),
    .reject_o(reject), .ea_o(ea)
  );

  // reference model
  int mem [256];
  int lk [3];
  int wr_rem, wa, wd, wl, ec, ed, ps, first, eaq, m_rej;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] = 'hFF;
      for (int i = 0; i < 3; i++) lk[i] = 0;
      wr_rem = 0; wa = 0; wd = 0; wl = 0; ec = 0; ed = 0;
      ps = 1; first = 1; eaq = 0; m_rej = 0;
    end else begin
      int busy, hold, rise, fall, r;
      busy = (wr_rem > 0);
      hold = (op == 3 && strobe == 1'b0);
      rise = (strobe == 1'b1 && ps == 0);
      fall = (strobe == 1'b0 && ps == 1);
      r = 0;
      if (busy != 0) begin
        wr_rem--;
        if (wr_rem == 0) begin
          if (wl != 0) begin
            if (wa % 4 < 3) lk[wa % 4] = 1;
          end else begin
            mem[wa] = mem[wa] & wd;
          end
        end
      end
      if (rise != 0 && (op == 1 || op == 2)) begin
        if (busy != 0) r = 1;
        else begin
          wr_rem = W; wa = int'(addr); wd = int'(din); wl = (op == 2);
        end
      end
      if (hold != 0 && fall != 0 && busy != 0) r = 1;
      if (hold == 0) begin
        ec = 0; ed = 0;
      end else if (busy != 0) begin
        ec = 0;
      end else if (ed == 0) begin
        ec++;
        if (ec == E) begin
          ec = 0; ed = 1;
          for (int i = 0; i < 256; i++) mem[i] = 'hFF;
          for (int i = 0; i < 3; i++) lk[i] = 0;
        end
      end
      if (first != 0) begin eaq = ext; first = 0; end
      m_rej = r;
      ps = strobe;
    end
  end

  function automatic int exp_data();
    int a;
    a = int'(addr);
    if (op == 0) begin
      if (lk[0] != 0 || lk[1] != 0) return 'hFF;
      if (wr_rem > 0 && wl == 0 && a == wa) return (~wd) & 'hFF;
      return mem[a];
    end else if (op == 4) begin
      if (a == 'h30) return 'h1E;
      if (a == 'h31) return 'h51;
      if (a == 'h32) return 'h05;
      return 'hFF;
    end
    return 'hFF;
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      int ed_v, er_v, ej_v, ea_v;
      ed_v = exp_data();
      er_v = !(wr_rem > 0 || ec > 0);
      ej_v = m_rej;
      ea_v = (lk[0] != 0) ? eaq : int'(ext);
      applied++;
      if (int'(dout) != ed_v || int'(ready) != er_v || int'(reject) != ej_v || int'(ea) != ea_v) begin
        fails++;
        $display("FAIL %s: data/ready/reject/ea actual %h/%0d/%0d/%0d expected %h/%0d/%0d/%0d",
                 cur_req, dout, ready, reject, ea, ed_v[7:0], er_v, ej_v, ea_v);
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    applied++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(int m, int a, int d, bit s);
    @(negedge clk); #1;
    op = 3'(m); addr = AW'(a); din = 8'(d); strobe = s;
  endtask

  task automatic pulse(int m, int a, int d);
    drive(m, a, d, 1'b0);
    drive(m, a, d, 1'b1);
  endtask

  task automatic settle(int n);
    repeat (n) drive(0, int'(addr), 0, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    cur_req = "R1";
    drive(0, 'h10, 0, 1); #1;
    chk("R1", int'(dout), 'hFF);
    chk("R1", int'(ready), 1);
    drive(0, 'hFE, 0, 1); #1;
    chk("R1", int'(dout), 'hFF);
    ext = 1'b0;
    // R10 unlocked: ea follows input
    cur_req = "R10";
    drive(0, 0, 0, 1); #1;
    chk("R10", int'(ea), 0);

    // R2/R3 byte write with polling
    cur_req = "R2";
    pulse(1, 'h10, 'hA5);
    drive(0, 'h10, 0, 1); #1;
    cur_req = "R3";
    chk("R3", int'(dout), 'h5A);
    chk("R2", int'(ready), 0);
    drive(0, 'h11, 0, 1); #1;
    chk("R3", int'(dout), 'hFF);
    drive(0, 'h10, 0, 1);
    settle(5); #1;
    chk("R2", int'(ready), 1);
    chk("R2", int'(dout), 'hA5);

    // R4 only clears bits
    cur_req = "R4";
    pulse(1, 'h10, 'h3C);
    settle(7); #1;
    chk("R4", int'(dout), 'h24);
    pulse(1, 'h40, 'h00);
    drive(0, 'h40, 0, 1);
    settle(6); #1;
    chk("R4", int'(dout), 'h00);

    // R5 request while busy
    cur_req = "R5";
    pulse(1, 'h20, 'hF0);
    pulse(1, 'h21, 'h00);
    drive(0, 'h21, 0, 1); #1;
    chk("R5", int'(reject), 1);
    settle(6); #1;
    chk("R5", int'(dout), 'hFF);
    drive(0, 'h20, 0, 1); #1;
    chk("R5", int'(dout), 'hF0);
    // request on final busy cycle
    pulse(1, 'h22, 'h0F);
    drive(0, 'h22, 0, 1);
    drive(0, 'h22, 0, 1);
    drive(0, 'h22, 0, 1);
    pulse(1, 'h23, 'h00);
    settle(8);
    // erase fall during pending write
    cur_req = "R6";
    pulse(1, 'h24, 'h77);
    drive(3, 0, 0, 0);
    drive(0, 0, 0, 0); #1;
    chk("R6", int'(reject), 1);
    settle(8);

    // R9 signature
    cur_req = "R9";
    drive(4, 'h30, 0, 1); #1; chk("R9", int'(dout), 'h1E);
    drive(4, 'h31, 0, 1); #1; chk("R9", int'(dout), 'h51);
    drive(4, 'h32, 0, 1); #1; chk("R9", int'(dout), 'h05);
    drive(4, 'h33, 0, 1); #1; chk("R9", int'(dout), 'hFF);
    drive(6, 'h10, 0, 1); #1; chk("R9", int'(dout), 'hFF);

    // R7 aborted erase
    cur_req = "R7";
    repeat (10) drive(3, 0, 0, 0);
    drive(0, 'h10, 0, 1); #1;
    chk("R7", int'(dout), 'h24);
    settle(2);

    // R8 lock bits
    cur_req = "R8";
    pulse(2, 'h02, 0);
    settle(7);
    drive(0, 'h10, 0, 1); #1;
    chk("R8", int'(dout), 'h24);
    pulse(2, 'h00, 0);
    settle(7);
    drive(0, 'h10, 0, 1); #1;
    chk("R8", int'(dout), 'hFF);
    cur_req = "R10";
    chk("R10", int'(ea), 1);
    ext = 1'b1;
    drive(0, 'h10, 0, 1);
    ext = 1'b0;
    drive(0, 'h10, 0, 1); #1;
    chk("R10", int'(ea), 1);

    // R6 full erase
    cur_req = "R6";
    drive(3, 0, 0, 0);
    drive(3, 0, 0, 0); #1;
    chk("R6", int'(ready), 0);
    repeat (22) drive(3, 0, 0, 0);
    drive(0, 'h20, 0, 1); #1;
    chk("R6", int'(dout), 'hFF);
    chk("R6", int'(ea), 0);
    pulse(1, 'h10, 'h5A);
    settle(7);
    drive(0, 'h10, 0, 1); #1;
    chk("R6", int'(dout), 'h5A);
    settle(3);

    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end
endmodule